// File: doc/BRIEF.md
# Far-end alarm code transmitter

This block sends a short far-end alarm or control message as a serial bit stream. Software writes a 6-bit code into a code register. It then writes the control register with the function enable and GO bits both set. The block wraps the code in a 16-bit codeword and sends that codeword ten times back to back. When the last bit of the tenth copy has gone out, the block clears its busy flag and sets a completion status bit. That status bit can raise an interrupt.

The serial side is a valid/ready stream of single bits. `tx_valid` is high while a message is in progress. `tx_ready` is the bit-slot strobe from the line side: a bit moves only on a clock edge where both are high. While `tx_ready` is low, `tx_data` and `tx_valid` hold their values, so the line side can stall the stream for as long as it needs.

The completion interrupt is gated twice. Its own enable in the control register must be 1, and the transmit-section enable in a separate block enable register must also be 1. Reading the control register returns the status and clears it in the same access.

Top module: `alarm_code_tx`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `tx_valid` is 0 and `tx_data` is 1.
- R2: The codeword goes out in this time order: a 0, then code bits 5 down to 0, then a 0, then eight 1s. One bit moves per clock edge with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_data` stays stable.
- R3: One accepted start sends the codeword exactly 10 times (160 bits). `tx_valid` falls right after the last bit.
- R4: A start is accepted only on a write to the control register (address 1) whose data has bit 2 (function enable) and bit 1 (GO) both at 1, while busy is 0. Any other write starts nothing, and a GO written while busy does not restart or extend the message.
- R5: Busy (control bit 0) reads 1 from the cycle after an accepted start until completion. It falls on the same clock edge that sets the completion status.
- R6: Completion sets status (control bit 3) whatever the interrupt enables are. A read of the control register returns the status and clears it.
- R7: `irq` is 1 only when status, the source enable (control bit 4) and the transmit-section enable (bit 1 of the block enable register at address 0) are all 1.
- R8: The 6-bit code is captured at start, so writing the code register during a message does not change the bits being sent.
- R9: If completion and a control-register read fall in the same cycle, the status ends up set.
- R10: A write to the control register with bit 2 at 0 during a message aborts it. Busy and `tx_valid` drop on the next edge, and status is not set.
- R11: Register map:
  - Address 0: bits 7, 4, 1 and 0 are read/write; the other bits read 0.
  - Address 1: bits 4, 2 and 1 are read/write; bits 7 to 5 read 0.
  - Address 2: bits 5 to 0 hold the code; bits 7 and 6 read 0.
  - Address 3: reads 0.
- R12: When no message is in progress, `tx_valid` is 0 and `tx_data` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; a read of address 1 clears status |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| tx_ready | input | 1 | Bit-slot strobe from the line side |
| tx_valid | output | 1 | A message bit is being presented |
| tx_data | output | 1 | Serial bit, 1 when idle |
| irq | output | 1 | Gated completion interrupt |

## Verification
The assertions assume three things about the inputs:
- `reg_wr` and `reg_rd` are single-cycle strobes.
- `tx_ready` may toggle freely from cycle to cycle.
- The only thing that may end a message early is a control write that clears the function enable.

The stimulus keeps to this. It drives bus accesses one at a time, between clock edges. It draws `tx_ready` from `$urandom`, at a randomly chosen density. It aborts a message only through that documented write, and it times the completion/read collision by hand, holding the strobe low before the final bit.

// File: rtl/alarm_tx_pkg.sv
package alarm_tx_pkg;
  localparam int REG_DW = 8;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] A_BLKEN = 2'd0;
  localparam logic [REG_AW-1:0] A_CTRL  = 2'd1;
  localparam logic [REG_AW-1:0] A_CODE  = 2'd2;

  // control register bit positions (software decodes these)
  localparam int C_IRQ_EN = 4;
  localparam int C_STATUS = 3;
  localparam int C_FN_EN  = 2;
  localparam int C_GO     = 1;
  localparam int C_BUSY   = 0;

  // block enable register bit positions
  localparam int B_RX  = 7;
  localparam int B_MUX = 4;
  localparam int B_TX  = 1;
  localparam int B_SEC = 0;

  typedef struct packed {
    logic irq_en;
    logic fn_en;
    logic go;
  } ctrl_t;

  typedef struct packed {
    logic rx;
    logic mux;
    logic tx;
    logic sec;
  } blken_t;
endpackage

// File: rtl/alarm_tx_regs.sv
module alarm_tx_regs
  import alarm_tx_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [REG_DW-1:0] rdata,
  input  logic              busy,
  input  logic              done,
  output logic              start,
  output logic              abort,
  output logic [CODE_W-1:0] code,
  output logic              status,
  output logic              src_irq_en,
  output logic              blk_tx_en
);
  ctrl_t             ctrl_q;
  blken_t            blk_q;
  logic [CODE_W-1:0] code_q;
  logic              status_q;

  logic wr_ctrl, rd_ctrl;
  assign wr_ctrl = wr && (addr == A_CTRL);
  assign rd_ctrl = rd && (addr == A_CTRL);

  assign start = wr_ctrl && wdata[C_FN_EN] && wdata[C_GO] && !busy;
  assign abort = wr_ctrl && !wdata[C_FN_EN] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      blk_q  <= '0;
      code_q <= '0;
    end else if (wr) begin
      unique case (addr)
        A_BLKEN: blk_q <= '{rx: wdata[B_RX], mux: wdata[B_MUX],
                            tx: wdata[B_TX], sec: wdata[B_SEC]};
        A_CTRL:  ctrl_q <= '{irq_en: wdata[C_IRQ_EN], fn_en: wdata[C_FN_EN],
                             go: wdata[C_GO]};
        A_CODE:  code_q <= wdata[CODE_W-1:0];
        default: ;
      endcase
    end
  end

  // completion wins over a simultaneous clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= 1'b0;
    else if (done)    status_q <= 1'b1;
    else if (rd_ctrl) status_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_BLKEN: begin
        rdata[B_RX]  = blk_q.rx;
        rdata[B_MUX] = blk_q.mux;
        rdata[B_TX]  = blk_q.tx;
        rdata[B_SEC] = blk_q.sec;
      end
      A_CTRL: begin
        rdata[C_IRQ_EN] = ctrl_q.irq_en;
        rdata[C_STATUS] = status_q;
        rdata[C_FN_EN]  = ctrl_q.fn_en;
        rdata[C_GO]     = ctrl_q.go;
        rdata[C_BUSY]   = busy;
      end
      A_CODE:  rdata[CODE_W-1:0] = code_q;
      default: ;
    endcase
  end

  assign code       = code_q;
  assign status     = status_q;
  assign src_irq_en = ctrl_q.irq_en;
  assign blk_tx_en  = blk_q.tx;
endmodule

// File: rtl/alarm_tx_serializer.sv
module alarm_tx_serializer #(
  parameter int CODE_W  = 6,
  parameter int WORD_W  = 16,
  parameter int REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CODE_W-1:0] code,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_data,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int REP_W = $clog2(REPEATS + 1);
  localparam int FLAG_W = WORD_W - CODE_W - 2;

  logic [WORD_W-1:0] word_n, word_q, sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [REP_W-1:0]  rep_q;
  logic              active_q;
  logic              beat, last_bit, last_rep;

  // 0, code MSB first, 0, then a run of ones
  always_comb begin
    word_n = '1;
    word_n[WORD_W-1] = 1'b0;
    word_n[FLAG_W]   = 1'b0;
    for (int i = 0; i < CODE_W; i++)
      word_n[WORD_W-2-i] = code[CODE_W-1-i];
  end

  assign beat     = active_q && tx_ready;
  assign last_bit = (idx_q == IDX_W'(WORD_W - 1));
  assign last_rep = (rep_q == REP_W'(REPEATS - 1));
  assign done     = beat && last_bit && last_rep && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      word_q   <= '1;
      sh_q     <= '1;
      idx_q    <= '0;
      rep_q    <= '0;
    end else if (abort) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      word_q   <= word_n;
      sh_q     <= word_n;
      idx_q    <= '0;
      rep_q    <= '0;
    end else if (beat) begin
      if (last_bit) begin
        idx_q <= '0;
        sh_q  <= word_q;
        if (last_rep) active_q <= 1'b0;
        else          rep_q    <= rep_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
        sh_q  <= {sh_q[WORD_W-2:0], 1'b1};
      end
    end
  end

  assign tx_valid = active_q;
  assign tx_data  = active_q ? sh_q[WORD_W-1] : 1'b1;
  assign busy     = active_q;
endmodule

// File: rtl/alarm_tx_irq.sv
module alarm_tx_irq (
  input  logic status,
  input  logic src_en,
  input  logic blk_en,
  output logic irq
);
  assign irq = status && src_en && blk_en;
endmodule

// File: rtl/alarm_code_tx.sv
module alarm_code_tx
  import alarm_tx_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int WORD_W  = 16,
  parameter int REPEATS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic              tx_data,
  output logic              irq
);
  logic              busy, done, start, abort;
  logic              status, src_irq_en, blk_tx_en;
  logic [CODE_W-1:0] code;

  alarm_tx_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata), .busy(busy), .done(done),
    .start(start), .abort(abort), .code(code), .status(status),
    .src_irq_en(src_irq_en), .blk_tx_en(blk_tx_en)
  );

  alarm_tx_serializer #(.CODE_W(CODE_W), .WORD_W(WORD_W), .REPEATS(REPEATS)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .code(code),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .busy(busy), .done(done)
  );

  alarm_tx_irq u_irq (
    .status(status), .src_en(src_irq_en), .blk_en(blk_tx_en), .irq(irq)
  );
endmodule

// File: rtl/alarm_tx_chk.sv
module alarm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_data,
  input logic irq,
  input logic busy,
  input logic status,
  input logic blk_tx_en,
  input logic start,
  input logic done,
  input logic abort
);
  a_r12_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> tx_data);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !abort |=> tx_valid && $stable(tx_data));

  a_r7_block_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_tx_en |-> !irq);

  a_r5_fall_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(abort) |-> status);

  a_r4_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy);

  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> status);

  a_r3_done_ends_stream: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tx_valid);

  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && !tx_valid);
endmodule

bind alarm_code_tx alarm_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .irq(irq), .busy(busy), .status(status),
  .blk_tx_en(blk_tx_en), .start(start), .done(done), .abort(abort)
);

// File: tb/sim_alarm_code_tx.sv
`timescale 1ns/1ps
module sim_alarm_code_tx;
  localparam int TOTAL = 160;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       tx_ready = 1'b0;
  logic       tx_valid, tx_data, irq;

  int checks = 0;
  int fails = 0;
  int beats = 0;
  int stop_at = 100000;
  bit dense = 1'b0;
  logic [15:0] cw_q = '1;

  always #10 clk = ~clk;

  alarm_code_tx u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  function automatic logic [15:0] codeword(input logic [5:0] c);
    return {1'b0, c, 1'b0, 8'hFF};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // line side: pick strobe at negedge, sample 5 ns before the edge
  always @(negedge clk) begin
    if (!rst_n) tx_ready = 1'b0;
    else tx_ready = (beats < stop_at) && (dense || ($urandom % 3 == 0));
    #5;
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        chk("R2 bit", tx_data, cw_q[15 - (beats % 16)]);
        beats++;
      end else if (!tx_valid) begin
        chk("R12 idle", tx_data, 1'b1);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic go(input logic [5:0] c, input logic [7:0] ctrl);
    cw_q = codeword(c);
    beats = 0;
    wr(2'd2, {2'b00, c});
    wr(2'd1, ctrl);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (tx_valid && n < 20000) begin @(negedge clk); n++; end
    #6;
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 / R11 reset contents
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg reset", v, 8'h00);
    end
    chk("R1 irq", irq, 1'b0);
    chk("R1 valid", tx_valid, 1'b0);
    chk("R12 idle data", tx_data, 1'b1);

    // R11 map
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R11 blken", v, 8'h93);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R11 code", v, 8'h3F);
    rd(2'd3, v); chk("R11 addr3", v, 8'h00);
    wr(2'd1, 8'hE0); rd(2'd1, v); chk("R11 ctrl high bits", v, 8'h00);

    // first run: R2 R3 R5 R6 R7
    go(6'h2A, 8'h16);
    rd(2'd1, v); chk("R5 busy mid-run", v, 8'h17);
    wait_idle();
    chk("R3 bit count", beats, TOTAL);
    chk("R7 irq on", irq, 1'b1);
    rd(2'd1, v); chk("R6 status set", v, 8'h1E);
    rd(2'd1, v); chk("R6 status cleared", v, 8'h16);
    chk("R7 irq off after read", irq, 1'b0);

    // R4 GO without function enable
    beats = 0;
    wr(2'd1, 8'h12);
    repeat (5) @(negedge clk);
    #6 chk("R4 no start valid", tx_valid, 1'b0);
    rd(2'd1, v); chk("R4 no start ctrl", v, 8'h12);

    // R8 code latched, R4 GO while busy ignored
    go(6'h15, 8'h16);
    repeat (30) @(negedge clk);
    wr(2'd2, 8'h3F);
    wr(2'd1, 8'h16);
    wait_idle();
    chk("R8/R4 count", beats, TOTAL);
    rd(2'd1, v); chk("R6 status", v, 8'h1E);

    // R7 block-level mask
    wr(2'd0, 8'h00);
    go(6'h07, 8'h16);
    wait_idle();
    chk("R7 block masked", irq, 1'b0);
    wr(2'd0, 8'h02);
    #1 chk("R7 block unmasked", irq, 1'b1);
    rd(2'd1, v); chk("R6 status under mask", v, 8'h1E);
    // source-level mask
    go(6'h38, 8'h06);
    wait_idle();
    chk("R7 source masked", irq, 1'b0);
    rd(2'd1, v); chk("R6 status src masked", v, 8'h0E);

    // R10 abort
    go(6'h11, 8'h16);
    repeat (20) @(negedge clk);
    wr(2'd1, 8'h10);
    #5 chk("R10 valid dropped", tx_valid, 1'b0);
    chk("R10 data idle", tx_data, 1'b1);
    chk("R10 partial", (beats < TOTAL), 1'b1);
    rd(2'd1, v); chk("R10 no status", v, 8'h10);

    // R9 completion meets clearing read
    stop_at = TOTAL - 1; dense = 1'b1;
    go(6'h2D, 8'h16);
    begin
      int n = 0;
      while (beats < TOTAL - 1 && n < 5000) begin @(negedge clk); n++; end
    end
    repeat (3) @(negedge clk);
    #2;
    tx_ready = 1'b1; reg_addr = 2'd1; reg_rd = 1'b1;
    #1 chk("R9 read before", reg_rdata, 8'h17);
    @(negedge clk); #1;
    reg_rd = 1'b0;
    stop_at = 100000;
    wait_idle();
    chk("R9 count", beats, TOTAL);
    rd(2'd1, v); chk("R9 status kept", v, 8'h1E);
    rd(2'd1, v); chk("R6 cleared after", v, 8'h16);

    // random runs
    for (int k = 0; k < 6; k++) begin
      logic [5:0] c;
      c = 6'($urandom);
      dense = ($urandom % 2) == 1;
      go(c, 8'h16);
      repeat ($urandom % 40) @(negedge clk);
      wr(2'd2, 8'($urandom));
      wait_idle();
      chk("R3 random count", beats, TOTAL);
      rd(2'd1, v); chk("R6 random status", v, 8'h1E);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    $urandom(32'h5EED);
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule